// File: doc/BRIEF.md
# Six-Phase Multicycle Instruction Sequencer

This block is a small multicycle processor core. It fetches 16-bit instructions from a word-addressed memory and runs each one through a fixed loop of up to six phases. The phases are instruction fetch, decode, address evaluation, operand fetch from memory, execute and result store. No two phases overlap. All memory traffic passes through an address staging register and a data staging register. Register-only arithmetic goes directly from decode to execute.

The datapath has a program counter, an instruction register, the two staging registers, an effective-address register, an eight-entry register file and a three-function ALU. The ALU adds, performs bitwise AND and performs bitwise NOT. The core supports register-mode add, AND and complement, a PC-relative load, and halt. It loops forever until it executes a halt instruction. It then parks in a halted state.

A current-phase output lets an observer follow the sequence. A write-back port shows every register-file update.

Top module: `seq_core`

## Requirements
- R1: A synchronous active-high reset sets the following state:
  - PC is set to the START_ADDR parameter (default 16'h0040).
  - The instruction, address-staging and data-staging registers are cleared to zero.
  - All eight registers are cleared to zero.
  - The phase is Fetch, `halted` is low and `mem_rd` is low.
- R2: `phase` uses this encoding: Fetch=0, Decode=1, EvalAddr=2, FetchOperand=3, Execute=4, Store=5, Halted=6. Phases only advance forward in that order.
  - Fetch lasts 4 cycles.
  - FetchOperand lasts 3 cycles.
  - Decode, EvalAddr, Execute and Store last 1 cycle each.
- R3: Fetch runs in four steps, one cycle each:
  1. The address register is loaded from PC.
  2. `mem_rd` is high for one wait cycle, with `mem_addr` held stable.
  3. The data register captures `mem_rdata`.
  4. The instruction register is loaded from the data register, and PC is incremented by one.
  Successive fetch addresses therefore follow PC.
- R4: Instruction fields:
  - The opcode is in bits 15:12. The destination register is in bits 11:9. Source 1 is in bits 8:6.
  - Add (opcode 0001) and AND (opcode 0101) take source 2 from bits 2:0.
  - Add writes source1+source2 modulo 2^16. AND writes source1&source2.
- R5: Complement (opcode 1001) writes the bitwise inverse of source 1 (bits 8:6) to the destination register.
- R6: Add, AND and complement skip EvalAddr and FetchOperand. Their phase sequence is Fetch, Decode, Execute, Store. They make no memory read beyond the instruction fetch.
- R7: Load (opcode 0010) runs every phase: Fetch, Decode, EvalAddr, FetchOperand, Execute, Store.
  - The effective address is the incremented PC plus the sign-extended 9-bit offset in bits 8:0, with 16-bit wraparound.
  - FetchOperand reads that address through the staging registers.
  - Store writes the word read to the destination register.
- R8: Any other opcode except 1111 is a no-op. After Decode the core returns to Fetch at the next address, and no register is written.
- R9: Halt (opcode 1111) ends after Decode in the Halted phase. The core stays there with `halted` high, and makes no further memory reads or register writes until reset.
- R10: During the single Store cycle of each instruction, `wb_valid` is high and `wb_reg`/`wb_data` show the destination index and the value written. At all other times `wb_valid` is low.
- R11: `mem_we` is never asserted, and `mem_wdata` shows the data-staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address, driven by the address-staging register |
| mem_rd | output | 1 | Read strobe; the memory must capture the address on this edge |
| mem_we | output | 1 | Write strobe, held low |
| mem_wdata | output | 16 | Write data, driven by the data-staging register |
| mem_rdata | input | 16 | Read data; valid one cycle after the `mem_rd` edge |
| phase | output | 3 | Current phase code (see R2) |
| halted | output | 1 | High once a halt instruction has executed |
| wb_valid | output | 1 | Register-file write this cycle |
| wb_reg | output | 3 | Destination register index |
| wb_data | output | 16 | Value written to the register file |

## Verification
The assertions rely on one property of the memory: on a clock edge where `mem_rd` is high, it registers the word at `mem_addr` and holds that word on `mem_rdata` through the next cycle. The assertions also assume reset is held for at least one clock edge before the first fetch. The bench memory is a registered array that reads only on the strobe edge. The bench raises reset for several edges and releases it just after a rising edge. The program includes the following cases:
- a read of never-written registers;
- a load whose address wraps below zero;
- two unrecognised opcodes;
- an overflowing add;
- an instruction placed after the halt, which must never be fetched.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int WORD_W  = 16;
    localparam int NREGS   = 8;
    localparam int RIDX_W  = $clog2(NREGS);
    localparam int OPC_W   = 4;
    localparam int OFF_W   = 9;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RIDX_W-1:0] ridx_t;
    typedef logic [OPC_W-1:0]  opc_t;

    localparam opc_t OPC_ADD  = 4'b0001;
    localparam opc_t OPC_LD   = 4'b0010;
    localparam opc_t OPC_AND  = 4'b0101;
    localparam opc_t OPC_NOT  = 4'b1001;
    localparam opc_t OPC_HALT = 4'b1111;

    typedef enum logic [2:0] {
        PH_FETCH   = 3'd0,
        PH_DECODE  = 3'd1,
        PH_EVAL    = 3'd2,
        PH_OPER    = 3'd3,
        PH_EXEC    = 3'd4,
        PH_STORE   = 3'd5,
        PH_HALT    = 3'd6
    } phase_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ea;
        logic mem_rd;
        logic mdr_load;
        logic ir_load;
        logic ea_load;
        logic res_load;
        logic rf_we;
        logic wb_from_mdr;
    } ctl_t;

    typedef struct packed {
        opc_t             opc;
        ridx_t            dst;
        ridx_t            src_a;
        ridx_t            src_b;
        logic [OFF_W-1:0] off;
    } fields_t;

    function automatic fields_t split_instr(word_t w);
        fields_t f;
        f.opc   = w[15:12];
        f.dst   = w[11:9];
        f.src_a = w[8:6];
        f.src_b = w[2:0];
        f.off   = w[OFF_W-1:0];
        return f;
    endfunction

    function automatic logic is_reg_op(opc_t o);
        return (o == OPC_ADD) || (o == OPC_AND) || (o == OPC_NOT);
    endfunction

    function automatic word_t sext_off(logic [OFF_W-1:0] o);
        return {{(WORD_W-OFF_W){o[OFF_W-1]}}, o};
    endfunction

endpackage

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int NREG = 8,
    parameter int W    = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb
);
    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && wa == AW'(g))
                regs[g] <= wd;
        end
    end

    assign qa = regs[ra];
    assign qb = regs[rb];
endmodule

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
#(
    parameter int W = 16
) (
    input  opc_t         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OPC_ADD: y = a + b;
            OPC_AND: y = a & b;
            OPC_NOT: y = ~a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int FETCH_STEPS = 4,
    parameter int OPER_STEPS  = 3,
    localparam int STEP_W     = $clog2(FETCH_STEPS + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  opc_t   opc,
    output phase_e phase,
    output ctl_t   ctl
);
    phase_e            ph, ph_nx;
    logic [STEP_W-1:0] step, step_nx;

    always_comb begin
        ph_nx   = ph;
        step_nx = step;
        ctl     = '0;
        unique case (ph)
            PH_FETCH: begin
                step_nx = step + 1'b1;
                case (step)
                    STEP_W'(0): ctl.mar_from_pc = 1'b1;
                    STEP_W'(1): ctl.mem_rd      = 1'b1;
                    STEP_W'(2): ctl.mdr_load    = 1'b1;
                    default:    ctl.ir_load     = 1'b1;
                endcase
                if (step == STEP_W'(FETCH_STEPS - 1)) begin
                    ph_nx   = PH_DECODE;
                    step_nx = '0;
                end
            end
            PH_DECODE: begin
                if (is_reg_op(opc))     ph_nx = PH_EXEC;
                else if (opc == OPC_LD) ph_nx = PH_EVAL;
                else if (opc == OPC_HALT) ph_nx = PH_HALT;
                else                    ph_nx = PH_FETCH;
            end
            PH_EVAL: begin
                ctl.ea_load = 1'b1;
                ph_nx       = PH_OPER;
            end
            PH_OPER: begin
                step_nx = step + 1'b1;
                case (step)
                    STEP_W'(0): ctl.mar_from_ea = 1'b1;
                    STEP_W'(1): ctl.mem_rd      = 1'b1;
                    default:    ctl.mdr_load    = 1'b1;
                endcase
                if (step == STEP_W'(OPER_STEPS - 1)) begin
                    ph_nx   = PH_EXEC;
                    step_nx = '0;
                end
            end
            PH_EXEC: begin
                ctl.res_load = 1'b1;
                ph_nx        = PH_STORE;
            end
            PH_STORE: begin
                ctl.rf_we       = 1'b1;
                ctl.wb_from_mdr = (opc == OPC_LD);
                ph_nx           = PH_FETCH;
            end
            default: ph_nx = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_FETCH;
            step <= '0;
        end else begin
            ph   <= ph_nx;
            step <= step_nx;
        end
    end

    assign phase = ph;

    // R2: a multi-cycle phase never runs past its step budget
    p_step_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_OPER) |-> (step < STEP_W'(OPER_STEPS)));
endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter logic [15:0] START_ADDR = 16'h0040
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_we,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic [2:0]  phase,
    output logic        halted,
    output logic        wb_valid,
    output logic [2:0]  wb_reg,
    output logic [15:0] wb_data
);
    word_t   pc, ir, mar, mdr, ea, res;
    fields_t fld;
    phase_e  ph;
    ctl_t    ctl;
    word_t   rf_a, rf_b, alu_y, wb_val;

    assign fld = split_instr(ir);

    seq_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .opc   (fld.opc),
        .phase (ph),
        .ctl   (ctl)
    );

    seq_regfile #(.NREG(NREGS), .W(WORD_W)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (ctl.rf_we),
        .wa  (fld.dst),
        .wd  (wb_val),
        .ra  (fld.src_a),
        .rb  (fld.src_b),
        .qa  (rf_a),
        .qb  (rf_b)
    );

    seq_alu #(.W(WORD_W)) u_alu (
        .op (fld.opc),
        .a  (rf_a),
        .b  (rf_b),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= START_ADDR;
            ir  <= '0;
            mar <= '0;
            mdr <= '0;
            ea  <= '0;
            res <= '0;
        end else begin
            if (ctl.mar_from_pc)      mar <= pc;
            else if (ctl.mar_from_ea) mar <= ea;
            if (ctl.mdr_load) mdr <= mem_rdata;
            if (ctl.ir_load) begin
                ir <= mdr;
                pc <= pc + 1'b1;
            end
            if (ctl.ea_load)  ea  <= pc + sext_off(fld.off);
            if (ctl.res_load) res <= alu_y;
        end
    end

    assign wb_val    = ctl.wb_from_mdr ? mdr : res;
    assign mem_addr  = mar;
    assign mem_rd    = ctl.mem_rd;
    assign mem_we    = 1'b0;
    assign mem_wdata = mdr;
    assign phase     = ph;
    assign halted    = (ph == PH_HALT);
    assign wb_valid  = ctl.rf_we;
    assign wb_reg    = fld.dst;
    assign wb_data   = wb_val;

    // R3: PC advances by one when Fetch hands over to Decode
    p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(ph) == PH_FETCH && ph == PH_DECODE) |-> (pc == $past(pc) + 1'b1));

    // R3: the decoded instruction is the word staged in the data register
    p_ir_from_mdr_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(ph) == PH_FETCH && ph == PH_DECODE) |-> (ir == $past(mdr)));

    // R3: address held through the cycle after the strobe
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> $stable(mem_addr));

    // R6: only the load reaches the address and operand phases
    p_mem_only_load_r6: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EVAL || ph == PH_OPER) |-> (fld.opc == OPC_LD));

    // R9: halted is final and silent
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_rd && !wb_valid));

    // R10: register writes happen only in Store
    p_wb_in_store_r10: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (ph == PH_STORE));
endmodule

// File: tb/tb_seq_core.sv
module tb_seq_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, wb_data;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, mem_we, halted, wb_valid;
    logic [2:0]  phase, wb_reg;

    localparam logic [15:0] START = 16'h0040;

    always #4 clk = ~clk;

    seq_core #(.START_ADDR(START)) dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .phase(phase), .halted(halted), .wb_valid(wb_valid),
        .wb_reg(wb_reg), .wb_data(wb_data)
    );

    logic [15:0] mem [256];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expectation queues
    logic [15:0] q_addr[$];  string q_addr_tag[$];
    logic [18:0] q_wb[$];    string q_wb_tag[$];
    logic [2:0]  q_ph[$];    int    q_len[$];  string q_ph_tag[$];

    task automatic exp_phase(input logic [2:0] p, input int n, input string tag);
        q_ph.push_back(p); q_len.push_back(n); q_ph_tag.push_back(tag);
    endtask

    function automatic logic [15:0] enc_rr(input logic [3:0] op, input int d, input int a, input int b);
        return {op, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] enc_ld(input int d, input logic [8:0] off);
        return {4'b0010, 3'(d), off};
    endfunction

    // driver: walk the program by the requirements and push expectations
    task automatic drive_program();
        logic [15:0] rg [8];
        logic [15:0] pc, ins, ea, v;
        for (int i = 0; i < 8; i++) rg[i] = '0;
        pc = START;
        for (int n = 0; n < 64; n++) begin
            ins = mem[pc[7:0]];
            q_addr.push_back(pc); q_addr_tag.push_back("R3");
            exp_phase(3'd0, 4, "R3");
            pc = pc + 16'd1;
            case (ins[15:12])
                4'b0001, 4'b0101, 4'b1001: begin
                    exp_phase(3'd1, 1, "R6");
                    exp_phase(3'd4, 1, "R6");
                    exp_phase(3'd5, 1, "R6");
                    if (ins[15:12] == 4'b0001) v = rg[ins[8:6]] + rg[ins[2:0]];
                    else if (ins[15:12] == 4'b0101) v = rg[ins[8:6]] & rg[ins[2:0]];
                    else v = ~rg[ins[8:6]];
                    rg[ins[11:9]] = v;
                    q_wb.push_back({ins[11:9], v});
                    if (n == 0) q_wb_tag.push_back("R1");
                    else if (ins[15:12] == 4'b1001) q_wb_tag.push_back("R5");
                    else q_wb_tag.push_back("R4");
                end
                4'b0010: begin
                    ea = pc + {{7{ins[8]}}, ins[8:0]};
                    exp_phase(3'd1, 1, "R7");
                    exp_phase(3'd2, 1, "R7");
                    exp_phase(3'd3, 3, "R7");
                    exp_phase(3'd4, 1, "R7");
                    exp_phase(3'd5, 1, "R7");
                    q_addr.push_back(ea); q_addr_tag.push_back("R7");
                    v = mem[ea[7:0]];
                    rg[ins[11:9]] = v;
                    q_wb.push_back({ins[11:9], v}); q_wb_tag.push_back("R7");
                end
                4'b1111: begin
                    exp_phase(3'd1, 1, "R9");
                    break;
                end
                default: exp_phase(3'd1, 1, "R8");
            endcase
        end
    endtask

    // monitor
    logic [2:0] cur_ph;
    int         cur_len;
    bit         we_seen = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            cur_ph  = 3'd0;
            cur_len = 0;
        end else begin
            if (mem_we) we_seen = 1'b1;
            if (phase == cur_ph) cur_len++;
            else begin
                if (q_ph.size() == 0)
                    chk(0, "R2", "unexpected phase change", {29'd0, cur_ph}, 32'd0);
                else begin
                    logic [2:0] ep; int el; string t;
                    ep = q_ph.pop_front(); el = q_len.pop_front(); t = q_ph_tag.pop_front();
                    chk(cur_ph == ep, t, "phase order", {29'd0, cur_ph}, {29'd0, ep});
                    chk(cur_len == el, "R2", "phase length", cur_len, el);
                end
                cur_ph  = phase;
                cur_len = 1;
            end
            if (mem_rd) begin
                if (q_addr.size() == 0)
                    chk(0, "R9", "unexpected read", {16'd0, mem_addr}, 32'd0);
                else begin
                    logic [15:0] ea; string t;
                    ea = q_addr.pop_front(); t = q_addr_tag.pop_front();
                    chk(mem_addr == ea, t, "read address", {16'd0, mem_addr}, {16'd0, ea});
                end
            end
            if (wb_valid) begin
                if (q_wb.size() == 0)
                    chk(0, "R10", "unexpected write-back", {13'd0, wb_reg, wb_data}, 32'd0);
                else begin
                    logic [18:0] e; string t;
                    e = q_wb.pop_front(); t = q_wb_tag.pop_front();
                    chk({wb_reg, wb_data} == e, t, "write-back reg/data",
                        {13'd0, wb_reg, wb_data}, {13'd0, e});
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h40] = enc_rr(4'b0001, 3, 4, 5);     // uses reset-cleared regs
        mem[8'h41] = enc_ld(1, 9'h03E);            // -> 0x0080
        mem[8'h42] = enc_ld(2, 9'h19F);            // 0x43 - 0x61 wraps to 0xFFE2
        mem[8'h43] = enc_rr(4'b0001, 3, 1, 2);
        mem[8'h44] = enc_rr(4'b0101, 4, 1, 3);
        mem[8'h45] = enc_rr(4'b1001, 5, 4, 0);
        mem[8'h46] = 16'h0000;                      // unknown opcode
        mem[8'h47] = enc_rr(4'b0001, 7, 5, 5);      // overflowing add
        mem[8'h48] = 16'hB123;                      // unknown opcode
        mem[8'h49] = 16'hF025;                      // halt
        mem[8'h4A] = enc_rr(4'b0001, 6, 1, 1);      // must never run
        mem[8'h80] = 16'h1234;
        mem[8'hE2] = 16'h80FF;

        drive_program();

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(phase == 3'd0, "R1", "reset phase", {29'd0, phase}, 32'd0);
        chk(!halted && !mem_rd && !wb_valid, "R1", "reset strobes",
            {29'd0, halted, mem_rd, wb_valid}, 32'd0);
        chk(mem_addr == 16'h0000, "R1", "reset address register", {16'd0, mem_addr}, 32'd0);
        chk(mem_wdata == 16'h0000, "R11", "reset data register", {16'd0, mem_wdata}, 32'd0);
        @(posedge clk); #1 rst = 1'b0;

        begin
            int cyc = 0;
            while (!halted && cyc < 5000) begin
                @(negedge clk);
                cyc++;
            end
            chk(halted, "R9", "watchdog: halt reached", {31'd0, halted}, 32'd1);
        end

        repeat (40) @(negedge clk);
        chk(halted && phase == 3'd6, "R9", "halt sticky", {28'd0, halted, phase}, {28'd0, 1'b1, 3'd6});
        chk(q_addr.size() == 0, "R3", "fetches left unseen", q_addr.size(), 0);
        chk(q_wb.size() == 0, "R10", "write-backs left unseen", q_wb.size(), 0);
        chk(q_ph.size() == 0, "R2", "phases left unseen", q_ph.size(), 0);
        chk(!we_seen, "R11", "write strobe seen", {31'd0, we_seen}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule